// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI function and answers configuration reads and writes on a simple target port. A request is presented for one cycle with a byte offset, a size in bytes (1, 2 or 4) and, for writes, right-aligned write data. Exactly one response comes back a fixed number of cycles later. The response carries right-aligned read data and an error flag.

The identity and class fields come from parameters and cannot be written. A small set of control bytes can be written. Each field accepts a write only at particular access widths. The block contains six base address registers (BARs) and an expansion ROM register. Each BAR is either legacy, which means frozen at zero, or programmable. A programmable BAR answers a write of all ones with its size mask, so that software can discover its size. For each programmable BAR the block presents the decoded base address and a valid flag. It raises a one-cycle range-changed pulse whenever a base moves.

All multi-byte fields are little-endian at the standard header positions:
- vendor 0x00, device 0x02
- command 0x04, status 0x06
- revision 0x08, class code 0x09..0x0B
- cache line size 0x0C, latency timer 0x0D
- header type 0x0E, BIST 0x0F
- BAR0..BAR5 at 0x10 + 4·i
- card information pointer 0x28
- subsystem vendor 0x2C, subsystem 0x2E
- ROM 0x30
- interrupt line 0x3C, interrupt pin 0x3D
- minimum grant 0x3E, maximum latency 0x3F

Top module: `cfg_hdr_regs`

## Requirements
- R1: A request whose size is not 1, 2 or 4 gets an error response, changes no state, and returns zero data. Every error response carries zero data.
- R2: A request that touches any byte at offset 0x40 or above (offset + size > 64) gets an error response and changes no state.
- R3: Suppose a request is present at rising edge n. `rsp_valid_o` is then high for exactly one cycle, the cycle after edge n + RSP_LAT − 1. At no other time is it high.
- R4: A read returns the addressed bytes little-endian and right-aligned, with zero above the access width. Identity fields read their parameter values. Write responses carry zero data.
- R5: A 1-byte write updates the cache line size (0x0C), the latency timer (0x0D) or the interrupt line (0x3C). A 1-byte write to 0x08, 0x0B, 0x3D, 0x3E or 0x3F is ignored without error. A 1-byte write to any other offset is an error and changes nothing.
- R6: A 2-byte write to 0x04 replaces the command word, and one to 0x06 replaces the status word. A 2-byte write to 0x0C replaces only the cache line size, from data bits [7:0]. A 2-byte write to any other offset is an error and changes nothing.
- R7: A 4-byte write to 0x04 replaces only the command word, from data bits [15:0]. A 4-byte write to any offset that is not 0x04, a BAR or 0x30 is ignored without error.
- R8: A 4-byte write of 0xFFFFFFFF to a programmable BAR stores ~(size − 1) with its type bits cleared, merged with the old type bits. A BAR of size zero reads back only its type bits.
- R9: A BAR's type mask is 0x3 if bit 0 of its current value is 1 (IO), and 0xF otherwise (memory). Any other write stores (data & ~mask) | (old & mask). Bit 0 never changes after reset.
- R10: A non-probe BAR write whose masked value is non-zero has three effects in the cycle after the accepting edge: it sets that BAR's `bar_base_o` slice to the masked value, it sets `bar_valid_o`, and it pulses `range_chg_o` high for that one cycle. Probe writes and zero masked writes leave the base unchanged and raise no pulse.
- R11: A legacy BAR reads zero, ignores every write without error, and keeps its base and valid outputs at zero.
- R12: A 4-byte write of 0xFFFFFFFE to the ROM register (0x30) stores 0xFFFFFFFF. Any other value is stored as written.
- R13: Reset establishes the following state. The command word, cache line size, latency timer and ROM are zero. The status word, interrupt line and BARs take their parameter values. All bases, valid flags, `range_chg_o` and `rsp_valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | 8 | Byte offset into configuration space |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Right-aligned write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Response error flag |
| rsp_rdata_o | output | 32 | Right-aligned read data |
| bar_base_o | output | 192 | Decoded base per BAR, BAR i in bits [32i+31:32i] |
| bar_valid_o | output | 6 | Base of BAR i has been programmed |
| range_chg_o | output | 1 | One-cycle pulse when any base changes |

## Verification
The bench sets the response latency to 3, so that the quiet cycles between acceptance and response can be observed. It uses the following BAR mix:
- BAR0: 4 KiB memory, prefetchable type bit set
- BAR1: 256-byte IO
- BAR2: size zero
- BAR3: legacy
- BAR4: 1 MiB memory with type bits 0x4
- BAR5: 32-byte IO

With this mix, both type masks, the zero-size probe, the frozen legacy slot and size masks of different lengths can all be reached in one run. The interrupt line and status word start from non-zero values, so that the reset image can be told apart from a cleared one.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int NUM_BAR   = 6;
  localparam int CFG_BYTES = 64;
  localparam int AW        = 8;

  localparam logic [AW-1:0] OFS_CMD   = 8'h04;
  localparam logic [AW-1:0] OFS_STAT  = 8'h06;
  localparam logic [AW-1:0] OFS_REV   = 8'h08;
  localparam logic [AW-1:0] OFS_CLASS = 8'h0B;
  localparam logic [AW-1:0] OFS_CLS   = 8'h0C;
  localparam logic [AW-1:0] OFS_LAT   = 8'h0D;
  localparam logic [AW-1:0] OFS_BAR0  = 8'h10;
  localparam logic [AW-1:0] OFS_ROM   = 8'h30;
  localparam logic [AW-1:0] OFS_ILINE = 8'h3C;
  localparam logic [AW-1:0] OFS_IPIN  = 8'h3D;
  localparam logic [AW-1:0] OFS_MGNT  = 8'h3E;
  localparam logic [AW-1:0] OFS_MLAT  = 8'h3F;

  localparam logic [31:0] IO_MASK  = 32'h0000_0003;
  localparam logic [31:0] MEM_MASK = 32'h0000_000F;

  typedef enum logic [1:0] {ACC_BYTE, ACC_HALF, ACC_WORD, ACC_BAD} acc_w_e;

  typedef struct packed {
    logic               cmd;
    logic               stat;
    logic               cls;
    logic               lat;
    logic               iline;
    logic               rom;
    logic [NUM_BAR-1:0] bar;
  } wr_sel_t;

  typedef struct packed {
    logic        valid;
    logic        err;
    logic [31:0] data;
  } rsp_t;
endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
  import cfg_hdr_pkg::*;
(
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [AW-1:0] offset_i,
  input  logic [2:0]    size_i,
  output logic          err_o,
  output wr_sel_t       sel_o
);
  acc_w_e    acc_w;
  logic [AW:0] end_addr;
  logic      range_err;
  logic      ro_err;
  wr_sel_t   sel_raw;

  always_comb begin
    unique case (size_i)
      3'd1:    acc_w = ACC_BYTE;
      3'd2:    acc_w = ACC_HALF;
      3'd4:    acc_w = ACC_WORD;
      default: acc_w = ACC_BAD;
    endcase
  end

  assign end_addr  = {1'b0, offset_i} + {6'd0, size_i};
  assign range_err = end_addr > (AW+1)'(CFG_BYTES);

  always_comb begin
    sel_raw = '0;
    ro_err  = 1'b0;
    unique case (acc_w)
      ACC_BYTE: begin
        unique case (offset_i)
          OFS_CLS:   sel_raw.cls   = 1'b1;
          OFS_LAT:   sel_raw.lat   = 1'b1;
          OFS_ILINE: sel_raw.iline = 1'b1;
          OFS_REV, OFS_CLASS, OFS_IPIN, OFS_MGNT, OFS_MLAT: ;
          default:   ro_err = 1'b1;
        endcase
      end
      ACC_HALF: begin
        unique case (offset_i)
          OFS_CMD:  sel_raw.cmd  = 1'b1;
          OFS_STAT: sel_raw.stat = 1'b1;
          OFS_CLS:  sel_raw.cls  = 1'b1;
          default:  ro_err = 1'b1;
        endcase
      end
      ACC_WORD: begin
        if (offset_i == OFS_CMD) sel_raw.cmd = 1'b1;
        if (offset_i == OFS_ROM) sel_raw.rom = 1'b1;
        for (int i = 0; i < NUM_BAR; i++)
          if (offset_i == OFS_BAR0 + AW'(4*i)) sel_raw.bar[i] = 1'b1;
      end
      default: ;
    endcase
  end

  assign err_o = (acc_w == ACC_BAD) || range_err || (write_i && ro_err);
  assign sel_o = (valid_i && write_i && !err_o) ? sel_raw : '0;
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter logic [31:0] SIZE   = 32'h0000_1000,
  parameter logic [31:0] INIT   = 32'h0000_0000,
  parameter bit          LEGACY = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] bar_o,
  output logic [31:0] base_o,
  output logic        valid_o,
  output logic        chg_o
);
  localparam logic [31:0] SIZE_MASK = ~(SIZE - 32'd1);

  if (LEGACY) begin : g_legacy
    logic unused_in;
    assign unused_in = &{clk_i, rst_ni, wr_i, wdata_i};
    assign bar_o   = '0;
    assign base_o  = '0;
    assign valid_o = 1'b0;
    assign chg_o   = 1'b0;
  end else begin : g_prog
    logic [31:0] bar_q, base_q, type_mask, new_hi;
    logic        valid_q, chg_q, probe;

    assign type_mask = bar_q[0] ? IO_MASK : MEM_MASK;
    assign probe     = &wdata_i;
    assign new_hi    = (probe ? SIZE_MASK : wdata_i) & ~type_mask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bar_q   <= INIT;
        base_q  <= '0;
        valid_q <= 1'b0;
        chg_q   <= 1'b0;
      end else begin
        chg_q <= 1'b0;
        if (wr_i) begin
          bar_q <= new_hi | (bar_q & type_mask);
          if (!probe && new_hi != '0) begin
            base_q  <= new_hi;
            valid_q <= 1'b1;
            chg_q   <= 1'b1;
          end
        end
      end
    end

    assign bar_o   = bar_q;
    assign base_o  = base_q;
    assign valid_o = valid_q;
    assign chg_o   = chg_q;

    assert_type_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> $stable(bar_q[0]));
    assert_base_move_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(base_q) |-> (chg_q && valid_q));
  end
endmodule

// File: rtl/cfg_rsp_pipe.sv
module cfg_rsp_pipe
  import cfg_hdr_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  rsp_t rsp_i,
  output rsp_t rsp_o
);
  rsp_t stg_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= rsp_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign rsp_o = stg_q[LAT-1];
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter int                     RSP_LAT          = 2,
  parameter logic [15:0]            VENDOR_ID        = 16'hA5C3,
  parameter logic [15:0]            DEVICE_ID        = 16'h0F21,
  parameter logic [7:0]             REVISION_ID      = 8'h01,
  parameter logic [23:0]            CLASS_CODE       = 24'h020000,
  parameter logic [7:0]             HEADER_TYPE      = 8'h00,
  parameter logic [7:0]             BIST_VAL         = 8'h00,
  parameter logic [31:0]            CIS_PTR          = 32'h0,
  parameter logic [15:0]            SUBSYS_VENDOR_ID = 16'h0000,
  parameter logic [15:0]            SUBSYS_ID        = 16'h0000,
  parameter logic [7:0]             INT_PIN          = 8'h01,
  parameter logic [7:0]             MIN_GNT          = 8'h00,
  parameter logic [7:0]             MAX_LAT          = 8'h00,
  parameter logic [15:0]            STATUS_INIT      = 16'h0000,
  parameter logic [7:0]             INT_LINE_INIT    = 8'hFF,
  parameter logic [NUM_BAR*32-1:0]  BAR_SIZE         = {32'h0, 32'h0, 32'h0, 32'h0, 32'h100, 32'h1000},
  parameter logic [NUM_BAR*32-1:0]  BAR_INIT         = {32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h0},
  parameter logic [NUM_BAR-1:0]     BAR_LEGACY       = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [7:0]            req_offset_i,
  input  logic [2:0]            req_size_i,
  input  logic [31:0]           req_wdata_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_err_o,
  output logic [31:0]           rsp_rdata_o,
  output logic [NUM_BAR*32-1:0] bar_base_o,
  output logic [NUM_BAR-1:0]    bar_valid_o,
  output logic                  range_chg_o
);
  localparam int IMG_W = CFG_BYTES * 8;

  logic          dec_err;
  wr_sel_t       sel;
  logic [15:0]   cmd_q, stat_q;
  logic [7:0]    cls_q, lat_q, iline_q;
  logic [31:0]   rom_q;
  logic [31:0]   bar_val [NUM_BAR];
  logic [NUM_BAR-1:0] bar_chg;
  logic [IMG_W-1:0]   img;
  logic [31:0]   rd_data;
  rsp_t          rsp_in, rsp_out;

  cfg_access_decode u_dec (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .offset_i(req_offset_i),
    .size_i  (req_size_i),
    .err_o   (dec_err),
    .sel_o   (sel)
  );

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
    cfg_bar_slot #(
      .SIZE  (BAR_SIZE[32*i +: 32]),
      .INIT  (BAR_INIT[32*i +: 32]),
      .LEGACY(BAR_LEGACY[i])
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (sel.bar[i]),
      .wdata_i(req_wdata_i),
      .bar_o  (bar_val[i]),
      .base_o (bar_base_o[32*i +: 32]),
      .valid_o(bar_valid_o[i]),
      .chg_o  (bar_chg[i])
    );
  end

  assign range_chg_o = |bar_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      stat_q  <= STATUS_INIT;
      cls_q   <= '0;
      lat_q   <= '0;
      iline_q <= INT_LINE_INIT;
      rom_q   <= '0;
    end else begin
      if (sel.cmd)   cmd_q   <= req_wdata_i[15:0];
      if (sel.stat)  stat_q  <= req_wdata_i[15:0];
      if (sel.cls)   cls_q   <= req_wdata_i[7:0];
      if (sel.lat)   lat_q   <= req_wdata_i[7:0];
      if (sel.iline) iline_q <= req_wdata_i[7:0];
      if (sel.rom)   rom_q   <= (req_wdata_i == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : req_wdata_i;
    end
  end

  // Little-endian header image
  always_comb begin
    img = '0;
    img[8*8'h00 +: 16] = VENDOR_ID;
    img[8*8'h02 +: 16] = DEVICE_ID;
    img[8*8'h04 +: 16] = cmd_q;
    img[8*8'h06 +: 16] = stat_q;
    img[8*8'h08 +: 8]  = REVISION_ID;
    img[8*8'h09 +: 24] = CLASS_CODE;
    img[8*8'h0C +: 8]  = cls_q;
    img[8*8'h0D +: 8]  = lat_q;
    img[8*8'h0E +: 8]  = HEADER_TYPE;
    img[8*8'h0F +: 8]  = BIST_VAL;
    for (int i = 0; i < NUM_BAR; i++) img[8*(16 + 4*i) +: 32] = bar_val[i];
    img[8*8'h28 +: 32] = CIS_PTR;
    img[8*8'h2C +: 16] = SUBSYS_VENDOR_ID;
    img[8*8'h2E +: 16] = SUBSYS_ID;
    img[8*8'h30 +: 32] = rom_q;
    img[8*8'h3C +: 8]  = iline_q;
    img[8*8'h3D +: 8]  = INT_PIN;
    img[8*8'h3E +: 8]  = MIN_GNT;
    img[8*8'h3F +: 8]  = MAX_LAT;
  end

  always_comb begin
    logic [8:0] a;
    rd_data = '0;
    for (int k = 0; k < 4; k++) begin
      a = {1'b0, req_offset_i} + 9'(k);
      if (3'(k) < req_size_i && a < 9'(CFG_BYTES))
        rd_data[8*k +: 8] = img[{a[5:0], 3'b000} +: 8];
    end
  end

  assign rsp_in.valid = req_valid_i;
  assign rsp_in.err   = req_valid_i && dec_err;
  assign rsp_in.data  = (req_valid_i && !dec_err && !req_write_i) ? rd_data : '0;

  cfg_rsp_pipe #(.LAT(RSP_LAT)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rsp_i (rsp_in),
    .rsp_o (rsp_out)
  );

  assign rsp_valid_o = rsp_out.valid;
  assign rsp_err_o   = rsp_out.err;
  assign rsp_rdata_o = rsp_out.data;

  assert_err_zero_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0));
  assert_err_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && dec_err) |=>
      ($stable(cmd_q) && $stable(stat_q) && $stable(cls_q) &&
       $stable(lat_q) && $stable(iline_q) && $stable(rom_q) && !range_chg_o));
  assert_rom_probe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_size_i == 3'd4 && req_offset_i == OFS_ROM &&
     req_wdata_i == 32'hFFFF_FFFE) |=> (rom_q == 32'hFFFF_FFFF));
  assert_rsp_no_err_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_err_o);
endmodule

// File: tb/cfg_hdr_regs_test.sv
module cfg_hdr_regs_test;
  localparam int          LAT     = 3;
  localparam logic [15:0] P_VEN   = 16'hA5C3;
  localparam logic [15:0] P_DEV   = 16'h0F21;
  localparam logic [7:0]  P_REV   = 8'h07;
  localparam logic [23:0] P_CLASS = 24'h028001;
  localparam logic [7:0]  P_HDR   = 8'h00;
  localparam logic [7:0]  P_BIST  = 8'h00;
  localparam logic [31:0] P_CIS   = 32'h0000_0000;
  localparam logic [15:0] P_SVEN  = 16'h5A11;
  localparam logic [15:0] P_SID   = 16'h0042;
  localparam logic [7:0]  P_IPIN  = 8'h01;
  localparam logic [7:0]  P_MGNT  = 8'h10;
  localparam logic [7:0]  P_MLAT  = 8'h20;
  localparam logic [15:0] P_STAT  = 16'h0290;
  localparam logic [7:0]  P_ILINE = 8'h0B;
  localparam logic [191:0] P_SIZE = {32'h20, 32'h10_0000, 32'h8, 32'h0, 32'h100, 32'h1000};
  localparam logic [191:0] P_INIT = {32'h1, 32'h4, 32'h3F9, 32'h0, 32'h1, 32'h8};
  localparam logic [5:0]   P_LEG  = 6'b001000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_ofs = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_err, range_chg;
  logic [31:0] rsp_rdata;
  logic [191:0] bar_base;
  logic [5:0] bar_valid;

  always #10 clk = ~clk;

  cfg_hdr_regs #(
    .RSP_LAT(LAT), .VENDOR_ID(P_VEN), .DEVICE_ID(P_DEV), .REVISION_ID(P_REV),
    .CLASS_CODE(P_CLASS), .HEADER_TYPE(P_HDR), .BIST_VAL(P_BIST), .CIS_PTR(P_CIS),
    .SUBSYS_VENDOR_ID(P_SVEN), .SUBSYS_ID(P_SID), .INT_PIN(P_IPIN), .MIN_GNT(P_MGNT),
    .MAX_LAT(P_MLAT), .STATUS_INIT(P_STAT), .INT_LINE_INIT(P_ILINE),
    .BAR_SIZE(P_SIZE), .BAR_INIT(P_INIT), .BAR_LEGACY(P_LEG)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_offset_i(req_ofs), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .bar_base_o(bar_base), .bar_valid_o(bar_valid), .range_chg_o(range_chg)
  );

  int n_run = 0, n_fail = 0;

  // model state
  logic [15:0] m_cmd, m_stat;
  logic [7:0]  m_cls, m_lat, m_iline;
  logic [31:0] m_rom;
  logic [31:0] m_bar [6];
  logic [31:0] m_base [6];
  logic [5:0]  m_valid;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] image();
    logic [511:0] v = '0;
    v[0 +: 16] = P_VEN;   v[16 +: 16] = P_DEV;
    v[32 +: 16] = m_cmd;  v[48 +: 16] = P_STAT == 0 ? m_stat : m_stat;
    v[64 +: 8] = P_REV;   v[72 +: 24] = P_CLASS;
    v[96 +: 8] = m_cls;   v[104 +: 8] = m_lat;
    v[112 +: 8] = P_HDR;  v[120 +: 8] = P_BIST;
    for (int i = 0; i < 6; i++) v[128 + 32*i +: 32] = m_bar[i];
    v[320 +: 32] = P_CIS; v[352 +: 16] = P_SVEN; v[368 +: 16] = P_SID;
    v[384 +: 32] = m_rom;
    v[480 +: 8] = m_iline; v[488 +: 8] = P_IPIN; v[496 +: 8] = P_MGNT; v[504 +: 8] = P_MLAT;
    return v;
  endfunction

  function automatic bit exp_err(bit w, int ofs, int sz);
    if (!(sz == 1 || sz == 2 || sz == 4)) return 1;
    if (ofs + sz > 64) return 1;
    if (!w) return 0;
    if (sz == 1) return !(ofs inside {'h0C, 'h0D, 'h3C, 'h08, 'h0B, 'h3D, 'h3E, 'h3F});
    if (sz == 2) return !(ofs inside {'h04, 'h06, 'h0C});
    return 0;
  endfunction

  function automatic string tag_of(bit w, int ofs, int sz);
    if (!(sz == 1 || sz == 2 || sz == 4)) return "R1";
    if (ofs + sz > 64) return "R2";
    if (!w) return "R4";
    if (sz == 1) return "R5";
    if (sz == 2) return "R6";
    if (ofs >= 'h10 && ofs < 'h28 && ofs % 4 == 0)
      return P_LEG[(ofs - 'h10) / 4] ? "R11" : "R9";
    if (ofs == 'h30) return "R12";
    return "R7";
  endfunction

  task automatic access(bit w, int ofs, int sz, logic [31:0] wd, string req);
    bit e;
    logic [31:0] exp_rd;
    bit exp_chg;
    logic [511:0] v;
    e = exp_err(w, ofs, sz);
    v = image();
    exp_rd = '0;
    if (!e && !w)
      for (int k = 0; k < sz; k++) exp_rd[8*k +: 8] = v[8*(ofs + k) +: 8];
    exp_chg = 0;
    if (!e && w) begin
      if (sz == 1) begin
        if (ofs == 'h0C) m_cls = wd[7:0];
        if (ofs == 'h0D) m_lat = wd[7:0];
        if (ofs == 'h3C) m_iline = wd[7:0];
      end else if (sz == 2) begin
        if (ofs == 'h04) m_cmd = wd[15:0];
        if (ofs == 'h06) m_stat = wd[15:0];
        if (ofs == 'h0C) m_cls = wd[7:0];
      end else begin
        if (ofs == 'h04) m_cmd = wd[15:0];
        if (ofs == 'h30) m_rom = (wd == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wd;
        for (int i = 0; i < 6; i++) begin
          if (ofs == 'h10 + 4*i && !P_LEG[i]) begin
            logic [31:0] mk, nw;
            mk = m_bar[i][0] ? 32'h3 : 32'hF;
            if (wd == 32'hFFFF_FFFF) nw = ~(P_SIZE[32*i +: 32] - 32'd1) & ~mk;
            else begin
              nw = wd & ~mk;
              if (nw != 0) begin m_base[i] = nw; m_valid[i] = 1'b1; exp_chg = 1; end
            end
            m_bar[i] = nw | (m_bar[i] & mk);
          end
        end
      end
    end
    req_valid = 1; req_write = w; req_ofs = 8'(ofs); req_size = 3'(sz); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({req, " R10 range pulse"}, 32'(range_chg), 32'(exp_chg));
    chk({req, " R10 valid"}, 32'(bar_valid), 32'(m_valid));
    for (int i = 0; i < 6; i++) chk({req, " R10 base"}, bar_base[32*i +: 32], m_base[i]);
    chk({req, " R3 early"}, 32'(rsp_valid), 32'd0);
    for (int d = 0; d < LAT - 1; d++) begin @(posedge clk); @(negedge clk); end
    chk({req, " R3 valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " err"}, 32'(rsp_err), 32'(e));
    chk({req, " data"}, rsp_rdata, exp_rd);
  endtask

  task automatic rd_expect(int ofs, logic [31:0] exp, string req);
    access(0, ofs, 4, 32'h0, req);
    chk({req, " literal"}, rsp_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_cmd = 0; m_stat = P_STAT; m_cls = 0; m_lat = 0; m_iline = P_ILINE; m_rom = 0;
    for (int i = 0; i < 6; i++) begin
      m_bar[i] = P_LEG[i] ? 32'h0 : P_INIT[32*i +: 32];
      m_base[i] = 0;
    end
    m_valid = 0;
    void'($urandom(32'd24601));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 rsp_valid", 32'(rsp_valid), 0);
    chk("R13 range_chg", 32'(range_chg), 0);
    chk("R13 bar_valid", 32'(bar_valid), 0);
    chk("R13 base0", bar_base[31:0], 0);
    rd_expect('h00, {P_DEV, P_VEN}, "R4 id");
    rd_expect('h04, {P_STAT, 16'h0}, "R13 cmd/stat");
    rd_expect('h3C, {P_MLAT, P_MGNT, P_IPIN, P_ILINE}, "R13 intr");
    rd_expect('h10, 32'h8, "R13 bar0");
    rd_expect('h1C, 32'h0, "R11 legacy read");
    access(0, 'h02, 2, 0, "R4 half read");
    chk("R4 half literal", rsp_rdata, {16'h0, P_DEV});
    access(0, 'h0B, 1, 0, "R4 byte read");
    chk("R4 byte literal", rsp_rdata, {24'h0, P_CLASS[23:16]});
    // R8 probes
    access(1, 'h10, 4, 32'hFFFF_FFFF, "R8 probe bar0");
    rd_expect('h10, 32'hFFFF_F008, "R8 bar0 mask");
    access(1, 'h14, 4, 32'hFFFF_FFFF, "R8 probe bar1 io");
    rd_expect('h14, 32'hFFFF_FF01, "R8 bar1 mask");
    access(1, 'h18, 4, 32'hFFFF_FFFF, "R8 probe size0");
    rd_expect('h18, 32'h0, "R8 bar2 zero");
    access(1, 'h20, 4, 32'hFFFF_FFFF, "R8 probe bar4");
    rd_expect('h20, 32'hFFF0_0004, "R8 bar4 mask");
    // R9/R10 programming
    access(1, 'h10, 4, 32'h1234_5007, "R10 bar0 program");
    rd_expect('h10, 32'h1234_5008, "R9 bar0 keep type");
    access(1, 'h24, 4, 32'h0000_C0E2, "R10 bar5 io program");
    rd_expect('h24, 32'h0000_C0E1, "R9 bar5 keep type");
    access(1, 'h10, 4, 32'h0000_0005, "R10 zero masked no pulse");
    // R11 legacy
    access(1, 'h1C, 4, 32'hFFFF_FFFF, "R11 legacy probe");
    access(1, 'h1C, 4, 32'h0000_2F8, "R11 legacy write");
    rd_expect('h1C, 32'h0, "R11 legacy stays zero");
    // R12 rom
    access(1, 'h30, 4, 32'hFFFF_FFFE, "R12 rom probe");
    rd_expect('h30, 32'hFFFF_FFFF, "R12 rom ones");
    access(1, 'h30, 4, 32'hABCD_0001, "R12 rom plain");
    rd_expect('h30, 32'hABCD_0001, "R12 rom value");
    // R1/R2 errors
    access(0, 'h00, 3, 0, "R1 size3");
    access(1, 'h0C, 0, 32'h55, "R1 size0 write");
    access(0, 'h40, 1, 0, "R2 offset 0x40");
    access(0, 'h3E, 4, 0, "R2 straddle");
    // R5/R6/R7
    access(1, 'h00, 1, 32'h77, "R5 ro byte err");
    access(1, 'h3D, 1, 32'h77, "R5 ignored pin");
    access(1, 'h0D, 1, 32'h40, "R5 lat byte");
    access(1, 'h02, 2, 32'h1111, "R6 ro half err");
    access(1, 'h0C, 2, 32'hBB10, "R6 half cls");
    rd_expect('h0C, {P_BIST, P_HDR, 8'h40, 8'h10}, "R6 cls only");
    access(1, 'h04, 4, 32'hDEAD_0147, "R7 dword cmd");
    rd_expect('h04, {P_STAT, 16'h0147}, "R7 cmd only");
    access(1, 'h00, 4, 32'h1234_5678, "R7 dword ignored");
    // random mix
    for (int it = 0; it < 400; it++) begin
      bit w;
      int ofs, sz;
      logic [31:0] wd;
      int sizes [9] = '{1, 2, 4, 1, 2, 4, 4, 3, 0};
      int hot [14] = '{'h04, 'h06, 'h0C, 'h0D, 'h10, 'h14, 'h18, 'h1C, 'h20, 'h24, 'h30, 'h3C, 'h3D, 'h3E};
      w = 1'($urandom % 2);
      sz = sizes[$urandom % 9];
      ofs = ($urandom % 2) ? hot[$urandom % 14] : int'($urandom % 72);
      case ($urandom % 4)
        0: wd = 32'hFFFF_FFFF;
        1: wd = 32'hFFFF_FFFE;
        default: wd = $urandom;
      endcase
      access(w, ofs, sz, wd, tag_of(w, ofs, sz));
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule